// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. On every cycle the distributor offers its best candidate for this processor: an identifier, a priority and, for software-generated interrupts, the number of the processor that raised it. The block compares the candidate against a programmable priority threshold. When the candidate qualifies and signalling is switched on, the block drives an interrupt request to the processor.

Software reads an acknowledge register to claim the interrupt. A successful claim returns the identifier. It sends a one-cycle pulse back to the distributor so that the distributor clears the pending bit, and it marks the identifier active in a local table. When the handler finishes, software writes the claimed value to an end-of-interrupt register. That write clears the active mark and sends a deactivate pulse to the distributor. If nothing qualifies, the acknowledge read returns the spurious value 1023.

A three-state machine drives the request line:
- **OFF**: signalling is disabled.
- **IDLE**: enabled, with no qualifying candidate.
- **SIGNAL**: the request output is high.

The transitions are:
- *enable*: OFF to IDLE.
- *raise*: OFF or IDLE to SIGNAL, when a candidate qualifies and no claim is taken this cycle.
- *claim*: SIGNAL to IDLE, on a successful acknowledge read.
- *withdraw*: SIGNAL to IDLE, when the candidate no longer qualifies.
- *disable*: any state to OFF, when the enable bit is clear.

Registers are selected by a 2-bit address:

| Address | Register | Access |
|---|---|---|
| 0 | control | read/write; bit 0 is the enable |
| 1 | priority threshold | read/write; 8 bits |
| 2 | acknowledge | read |
| 3 | end of interrupt | write |

Reads return data one cycle after the read strobe.

Top module: `cpu_irq_ack`

## Requirements
- R1: After reset the request output is low, the acknowledge and deactivate pulses are low, and the control and threshold registers read as 0. No identifier is active.
- R2: While control bit 0 is clear, the request output stays low and an acknowledge read returns 1023.
- R3: A candidate qualifies only if its priority is strictly less than the threshold. Equal priority does not qualify.
- R4: The request output rises on the clock edge after the cycle in which a candidate first qualifies, and it follows the candidate cycle by cycle.
- R5: A successful acknowledge read returns the identifier in bits 9:0. For identifiers below 16 it returns the source processor number in bits 12:10. Bits 12:10 are 0 for identifiers of 16 and above, and bits 31:13 are always 0.
- R6: An acknowledge read when nothing qualifies returns 1023, produces no acknowledge pulse and changes no state.
- R7: A successful acknowledge read emits a one-cycle acknowledge pulse carrying the identifier and marks the identifier active on that same edge. The request output is low from that edge on.
- R8: A candidate whose identifier is active does not qualify, so the request output stays low until another candidate qualifies.
- R9: An end-of-interrupt write whose bits 9:0 name an active identifier clears it and emits a one-cycle deactivate pulse with that identifier. Bits 12:10 of the write are ignored.
- R10: An end-of-interrupt write naming an identifier that is not active, or that is out of range, produces no pulse and changes no state.
- R11: Candidate identifiers at or above the configured identifier count never qualify.
- R12: Writes to address 0 set the enable from bit 0, and writes to address 1 set the 8-bit threshold. Both registers read back their stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| cand_valid_i | input | 1 | Distributor offers a candidate |
| cand_id_i | input | 10 | Candidate identifier |
| cand_prio_i | input | PRIO_W | Candidate priority (lower is more urgent) |
| cand_src_i | input | 3 | Requesting processor, for identifiers below 16 |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_valid_o | output | 1 | Pulse: clear pending for ack_id_o |
| ack_id_o | output | 10 | Identifier being claimed |
| eoi_valid_o | output | 1 | Pulse: deactivate eoi_id_o |
| eoi_id_o | output | 10 | Identifier being deactivated |

## Verification
The bench targets the following corner cases:
- **Equal priority.** A candidate whose priority equals the threshold is tested. A comparator using less-or-equal would raise the request at that priority.
- **Source-processor field.** Reads of identifiers just below and just above 16 are checked. A design that leaks the source-processor field into peripheral identifiers, or drops it for software interrupts, returns a wrong value.
- **Candidate held after a claim.** The candidate is kept on the inputs after its acknowledge. A design that fails to consult the active table keeps the request high or claims the same identifier twice.
- **Unclaimed completion.** End-of-interrupt writes name an inactive identifier and an out-of-range identifier. A design that skips the active check emits a spurious deactivate pulse.
- **Disabled interface.** Acknowledge reads are issued while the interface is disabled. A design that ignores the enable bit hands out live identifiers.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
    localparam int ID_W   = 10;
    localparam int CPU_W  = 3;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int WORD_W = ID_W + CPU_W;

    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
    localparam logic [ID_W-1:0] SGI_LIMIT   = 10'd16;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 2'd0,
        RA_MASK = 2'd1,
        RA_ACK  = 2'd2,
        RA_EOI  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SIGNAL = 2'd2
    } fsm_state_e;
endpackage

// File: rtl/icpu_regs.sv
module icpu_regs
    import icpu_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PRIO_W-1:0] wdata_i,
    input  logic [WORD_W-1:0] ack_word_i,
    output logic              en_o,
    output logic [PRIO_W-1:0] pmr_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W = DATA_W - WORD_W;
    localparam int PMR_PAD_W = DATA_W - PRIO_W;

    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        unique case (addr_i)
            RA_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, en_o};
            RA_MASK: rd_mux = {{PMR_PAD_W{1'b0}}, pmr_o};
            RA_ACK:  rd_mux = {{PAD_W{1'b0}}, ack_word_i};
            RA_EOI:  rd_mux = '0;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_o    <= 1'b0;
            pmr_o   <= '0;
            rdata_o <= '0;
        end else begin
            if (wr_i && addr_i == RA_CTRL) en_o  <= wdata_i[0];
            if (wr_i && addr_i == RA_MASK) pmr_o <= wdata_i;
            if (rd_i)                      rdata_o <= rd_mux;
        end
    end

    AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == RA_CTRL) |=> (en_o == $past(wdata_i[0]))); // R12
endmodule

// File: rtl/icpu_active.sv
module icpu_active
    import icpu_pkg::*;
#(
    parameter int NUM_IDS = 64
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            set_en_i,
    input  logic [ID_W-1:0] set_id_i,
    input  logic            clr_req_i,
    input  logic [ID_W-1:0] clr_id_i,
    input  logic [ID_W-1:0] query_id_i,
    output logic            clr_fire_o,
    output logic            query_active_o
);
    localparam int IDX_W = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;

    logic [NUM_IDS-1:0] act_q;
    logic               clr_in_range;
    logic               query_in_range;

    assign clr_in_range   = int'(clr_id_i) < NUM_IDS;
    assign query_in_range = int'(query_id_i) < NUM_IDS;
    assign clr_fire_o     = clr_req_i && clr_in_range && act_q[clr_id_i[IDX_W-1:0]];
    assign query_active_o = query_in_range && act_q[query_id_i[IDX_W-1:0]];

    generate
        for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    act_q[g] <= 1'b0;
                end else if (set_en_i && int'(set_id_i) == g) begin
                    act_q[g] <= 1'b1;
                end else if (clr_fire_o && int'(clr_id_i) == g) begin
                    act_q[g] <= 1'b0;
                end
            end
        end
    endgenerate

    AST_CLAIM_MARKS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_en_i |=> act_q[$past(set_id_i[IDX_W-1:0])]); // R7
    AST_EOI_CLEARS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_fire_o && !(set_en_i && set_id_i == clr_id_i))
            |=> !act_q[$past(clr_id_i[IDX_W-1:0])]); // R9
endmodule

// File: rtl/icpu_fsm.sv
module icpu_fsm
    import icpu_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int PRIO_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [PRIO_W-1:0] pmr_i,
    input  logic              cand_valid_i,
    input  logic [ID_W-1:0]   cand_id_i,
    input  logic [PRIO_W-1:0] cand_prio_i,
    input  logic [CPU_W-1:0]  cand_src_i,
    input  logic              cand_active_i,
    input  logic              ack_rd_i,
    output logic              irq_o,
    output logic              ack_take_o,
    output logic [WORD_W-1:0] ack_word_o
);
    fsm_state_e state_q, state_d;
    logic       qualify;
    logic [CPU_W-1:0] src_field;

    assign qualify = en_i && cand_valid_i && (int'(cand_id_i) < NUM_IDS)
                  && !cand_active_i && (cand_prio_i < pmr_i);
    assign ack_take_o = ack_rd_i && qualify;
    assign src_field  = (cand_id_i < SGI_LIMIT) ? cand_src_i : '0;
    assign ack_word_o = ack_take_o ? {src_field, cand_id_i} : {{CPU_W{1'b0}}, SPURIOUS_ID};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (qualify && !ack_take_o) state_d = ST_SIGNAL;
                else if (en_i)              state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!en_i)                       state_d = ST_OFF;
                else if (qualify && !ack_take_o) state_d = ST_SIGNAL;
            end
            ST_SIGNAL: begin
                if (!en_i)                        state_d = ST_OFF;
                else if (ack_take_o || !qualify)  state_d = ST_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == ST_SIGNAL);
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(en_i)); // R2
    AST_IRQ_STRICT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(cand_prio_i < pmr_i)); // R3
    AST_IRQ_NOT_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> !$past(cand_active_i)); // R8
endmodule

// File: rtl/cpu_irq_ack.sv
module cpu_irq_ack
    import icpu_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int PRIO_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cand_valid_i,
    input  logic [9:0]        cand_id_i,
    input  logic [PRIO_W-1:0] cand_prio_i,
    input  logic [2:0]        cand_src_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o,
    output logic              ack_valid_o,
    output logic [9:0]        ack_id_o,
    output logic              eoi_valid_o,
    output logic [9:0]        eoi_id_o
);
    logic              en;
    logic [PRIO_W-1:0] pmr;
    logic              ack_take;
    logic [WORD_W-1:0] ack_word;
    logic              cand_active;
    logic              eoi_req;
    logic              eoi_fire;
    logic              unused_wdata_bits;

    assign unused_wdata_bits = ^reg_wdata_i[DATA_W-1:ID_W];
    assign eoi_req = reg_wr_i && (reg_addr_i == RA_EOI);

    icpu_regs #(.PRIO_W(PRIO_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_i       (reg_rd_i),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i[PRIO_W-1:0]),
        .ack_word_i (ack_word),
        .en_o       (en),
        .pmr_o      (pmr),
        .rdata_o    (reg_rdata_o)
    );

    icpu_active #(.NUM_IDS(NUM_IDS)) u_active (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .set_en_i       (ack_take),
        .set_id_i       (cand_id_i),
        .clr_req_i      (eoi_req),
        .clr_id_i       (reg_wdata_i[ID_W-1:0]),
        .query_id_i     (cand_id_i),
        .clr_fire_o     (eoi_fire),
        .query_active_o (cand_active)
    );

    icpu_fsm #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W)) u_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .en_i          (en),
        .pmr_i         (pmr),
        .cand_valid_i  (cand_valid_i),
        .cand_id_i     (cand_id_i),
        .cand_prio_i   (cand_prio_i),
        .cand_src_i    (cand_src_i),
        .cand_active_i (cand_active),
        .ack_rd_i      (reg_rd_i && (reg_addr_i == RA_ACK)),
        .irq_o         (irq_o),
        .ack_take_o    (ack_take),
        .ack_word_o    (ack_word)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ack_valid_o <= 1'b0;
            ack_id_o    <= '0;
            eoi_valid_o <= 1'b0;
            eoi_id_o    <= '0;
        end else begin
            ack_valid_o <= ack_take;
            eoi_valid_o <= eoi_fire;
            if (ack_take) ack_id_o <= cand_id_i;
            if (eoi_fire) eoi_id_o <= reg_wdata_i[ID_W-1:0];
        end
    end

    AST_CLAIM_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_valid_o |-> !irq_o); // R7
    AST_EOI_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eoi_valid_o |-> $past(reg_wr_i && reg_addr_i == RA_EOI)); // R10
    AST_CLAIM_FROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_valid_o |-> $past(reg_rd_i && reg_addr_i == RA_ACK && en)); // R6
endmodule

// File: tb/cpu_irq_ack_bench.sv
`timescale 1ns/1ps
module cpu_irq_ack_bench;
    localparam int NUM_IDS = 64;
    localparam int PRIO_W  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cand_valid = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [7:0]  cand_prio = '0;
    logic [2:0]  cand_src = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, ack_valid, eoi_valid;
    logic [9:0]  ack_id, eoi_id;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    bit m_en = 0;
    int m_pmr = 0;
    bit m_act [NUM_IDS];
    bit e_irq, e_ackv, e_eoiv, e_rd;
    int e_ackid, e_eoiid, e_rdata;

    always #4 clk = ~clk;

    cpu_irq_ack #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W)) u_cpu_irq_ack (
        .clk_i(clk), .rst_ni(rst_n), .cand_valid_i(cand_valid), .cand_id_i(cand_id),
        .cand_prio_i(cand_prio), .cand_src_i(cand_src), .reg_rd_i(reg_rd),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq), .ack_valid_o(ack_valid),
        .ack_id_o(ack_id), .eoi_valid_o(eoi_valid), .eoi_id_o(eoi_id)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Behavioural reference: one register-port operation per cycle
    task automatic step(input bit rd, input bit wr, input int addr, input int wd);
        bit qual, take;
        int wid;
        reg_rd = rd; reg_wr = wr; reg_addr = 2'(addr); reg_wdata = wd;
        qual = m_en && cand_valid && (int'(cand_id) < NUM_IDS) && (int'(cand_prio) < m_pmr);
        if (qual) qual = !m_act[int'(cand_id)];
        take = rd && addr == 2 && qual;
        e_rd = rd;
        if (rd) begin
            case (addr)
                0: e_rdata = m_en;
                1: e_rdata = m_pmr;
                2: e_rdata = take ? (((int'(cand_id) < 16) ? int'(cand_src) << 10 : 0) + int'(cand_id)) : 1023;
                default: e_rdata = 0;
            endcase
        end
        e_ackv = take;
        if (take) e_ackid = int'(cand_id);
        wid = wd & 32'h3FF;
        e_eoiv = wr && addr == 3 && wid < NUM_IDS && m_act[wid < NUM_IDS ? wid : 0];
        if (e_eoiv) begin e_eoiid = wid; m_act[wid] = 0; end
        if (wr && addr == 0) m_en = wd[0];
        if (wr && addr == 1) m_pmr = wd & 8'hFF;
        if (take) m_act[int'(cand_id)] = 1;
        e_irq = qual && !take;
        @(posedge clk);
        @(negedge clk);
        chk("R4 irq", int'(irq), int'(e_irq));
        chk("R7 ack pulse", int'(ack_valid), int'(e_ackv));
        if (e_ackv) chk("R7 ack id", int'(ack_id), e_ackid);
        chk("R9 eoi pulse", int'(eoi_valid), int'(e_eoiv));
        if (e_eoiv) chk("R9 eoi id", int'(eoi_id), e_eoiid);
        if (e_rd) chk("R5 rdata", int'(reg_rdata), e_rdata);
        reg_rd = 0; reg_wr = 0;
    endtask

    task automatic cand(input bit v, input int id, input int prio, input int src);
        cand_valid = v; cand_id = 10'(id); cand_prio = 8'(prio); cand_src = 3'(src);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        foreach (m_act[i]) m_act[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 ack", int'(ack_valid), 0);
        chk("R1 eoi", int'(eoi_valid), 0);
        step(1, 0, 0, 0); chk("R1 ctrl", int'(reg_rdata), 0);
        step(1, 0, 1, 0); chk("R1 mask", int'(reg_rdata), 0);
        // R12 threshold, still disabled
        step(0, 1, 1, 32'h1F0); step(1, 0, 1, 0); chk("R12 mask", int'(reg_rdata), 32'hF0);
        // R2 disabled: no irq, spurious ack
        cand(1, 40, 8'hA0, 2);
        step(0, 0, 0, 0); step(0, 0, 0, 0); chk("R2 irq off", int'(irq), 0);
        step(1, 0, 2, 0); chk("R2 spurious", int'(reg_rdata), 1023);
        // R12 enable
        step(0, 1, 0, 32'hFFFF_FFFF); step(1, 0, 0, 0); chk("R12 ctrl", int'(reg_rdata), 1);
        // R4 request follows candidate
        step(0, 0, 0, 0); chk("R4 raised", int'(irq), 1);
        // R3 equal priority does not qualify, one below does
        cand(1, 40, 8'hF0, 2); step(0, 0, 0, 0); chk("R3 equal", int'(irq), 0);
        cand(1, 40, 8'hEF, 2); step(0, 0, 0, 0); chk("R3 below", int'(irq), 1);
        // R5 peripheral id carries no source field; R7 claim
        step(1, 0, 2, 0);
        chk("R5 periph", int'(reg_rdata), 40);
        chk("R7 pulse", int'(ack_valid), 1);
        chk("R7 irq low", int'(irq), 0);
        // R8 same candidate held, stays low
        step(0, 0, 0, 0); step(0, 0, 0, 0); chk("R8 held", int'(irq), 0);
        step(1, 0, 2, 0); chk("R8 no reclaim", int'(reg_rdata), 1023);
        // R10 EOI for inactive and out-of-range ids
        step(0, 1, 3, 41); chk("R10 inactive", int'(eoi_valid), 0);
        step(0, 1, 3, 1020); chk("R10 range", int'(eoi_valid), 0);
        chk("R10 still low", int'(irq), 0);
        // R9 EOI with junk in bits 12:10
        step(0, 1, 3, (7 << 10) | 40);
        chk("R9 pulse", int'(eoi_valid), 1);
        chk("R9 id", int'(eoi_id), 40);
        step(0, 0, 0, 0); chk("R9 re-raised", int'(irq), 1);
        step(0, 1, 3, 40); chk("R10 twice", int'(eoi_valid), 0);
        // R5 software interrupt boundary: ids 15 and 16
        cand(1, 15, 8'h10, 5); step(0, 0, 0, 0);
        step(1, 0, 2, 0); chk("R5 sgi", int'(reg_rdata), (5 << 10) | 15);
        cand(1, 16, 8'h10, 5); step(0, 0, 0, 0);
        step(1, 0, 2, 0); chk("R5 id16", int'(reg_rdata), 16);
        // R6 nothing qualifies
        cand(0, 20, 8'h10, 1); step(0, 0, 0, 0);
        step(1, 0, 2, 0);
        chk("R6 spurious", int'(reg_rdata), 1023);
        chk("R6 no pulse", int'(ack_valid), 0);
        // R11 out-of-range candidate
        cand(1, 1020, 8'h00, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
        chk("R11 no irq", int'(irq), 0);
        // R2 disable drops request
        cand(1, 30, 8'h00, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
        chk("R4 again", int'(irq), 1);
        step(0, 1, 0, 0); step(0, 0, 0, 0); chk("R2 disabled", int'(irq), 0);
        step(1, 0, 2, 0); chk("R2 ack off", int'(reg_rdata), 1023);
        // cleanup of earlier claims, sweep of mixed patterns
        step(0, 1, 0, 1);
        for (int k = 0; k < 40; k++) begin
            cand(k % 3 != 0, (k * 7) % 70, (k * 37) % 256, k % 8);
            step(k % 4 == 1, k % 5 == 2, (k % 4 == 1) ? 2 : 3, (k * 7) % 70);
        end
        summary();
    end
endmodule